// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block is a watchdog timer on a simple byte-addressed register bus. Once enabled, it counts down a first preload value and then a second preload value, one step per prescaled tick. When the second stage runs out, it sets a sticky timeout flag and can raise a reset request for a fixed number of clocks. Two input selects set the tick rate: a coarse divide of 2^COARSE_SH and a fine divide of 2^FINE_SH.

The two preload registers and the reload/status register are guarded by a key. Software first writes byte 0x80 and then byte 0x86 to the key address. That opens the guard for exactly one later protected write. A lock bit freezes the setup until power-on reset. Software keeps the watchdog alive with a keyed reload write. The timeout flag survives the reset request that the block itself raises, so software can tell after a restart that the watchdog fired.

Top module: `wdog_keyed`

## Requirements
- R1: A write to a protected offset (0x00 first preload, 0x04 second preload, 0x0D reload/status) takes effect only if the two writes before it that touched the key or a protected offset were 0x80 and then 0x86 (low data byte) at offset 0x0C, with no other bus write between the 0x80 and the 0x86; otherwise it is ignored.
- R2: One key sequence opens the guard for only the next protected write; a second protected write without a new key is ignored.
- R3: After the enable bit (bit 1 at 0x18) goes from 0 to 1, the timeout flag rises exactly (P1+P2+2)*2^S clocks later. P1 and P2 are the preloads; S is COARSE_SH when bit 2 of 0x10 is 0 and FINE_SH when it is 1.
- R4: Offset 0x14 reads the live down-counter: P1 right after start, and P2 at the tick that ends the first stage.
- R5: A keyed write with bit 0 set at 0x0D restarts the count at stage one with the full P1, leaves the timeout flag unchanged, and the next timeout follows R3 timing from that write.
- R6: The timeout flag reads at bit 1 of 0x0D and stays set until rst_n or a keyed write with bit 1 set at 0x0D.
- R7: With bit 4 of 0x10 set, rst_out is high for exactly RST_CYC clocks starting when the flag is set, and rst_kind copies bit 3 of 0x10 during the pulse; with bit 4 clear, rst_out stays low.
- R8: tmo_out is high exactly when the flag is set and bit 5 of 0x10 is set.
- R9: Writing 0 to the enable bit stops the count; the counter value holds and no timeout occurs.
- R10: Bit 0 of 0x18 (lock), once set, stays set until rst_n. While it is set, writes to 0x10, to the preloads and to 0x18 are ignored, but keyed reloads and flag clears still work.
- R11: Bit 2 of 0x18 picks the behaviour at expiry: 0 restarts at stage one, so timeouts repeat; 1 halts with the counter at 0 until a reload or a new enable.
- R12: After rst_n, every readable offset returns 0 and rst_out and tmo_out are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | AW | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data; byte registers use the low bits |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rst_out | output | 1 | Reset request pulse on timeout |
| rst_kind | output | 1 | Reset type selected for the current pulse |
| tmo_out | output | 1 | Timeout indication when enabled |

## Verification
The bench sweeps small preload pairs under both prescaler selects and measures the clock count to the timeout flag. A stage that is off by one tick, or a prescaler that drops or adds a cycle, shows up as a miscount. It breaks the key sequence in two ways and reuses one key twice. A guard that stays open, or that accepts a partial key, would let a preload change. It checks that a reload leaves the flag alone, that the reset pulse has the exact length and type, and that both expiry modes produce the right number of pulses. Lock checks confirm that frozen fields do not move while reload still works; a lock that can be cleared by a write would show a changed lock value.

// File: rtl/wdog_keyed_pkg.sv
`timescale 1ns/1ps
package wdog_keyed_pkg;
   localparam logic [7:0] OFF_PV1 = 8'h00;
   localparam logic [7:0] OFF_PV2 = 8'h04;
   localparam logic [7:0] OFF_KEY = 8'h0C;
   localparam logic [7:0] OFF_RL1 = 8'h0D;
   localparam logic [7:0] OFF_CFG = 8'h10;
   localparam logic [7:0] OFF_CNT = 8'h14;
   localparam logic [7:0] OFF_LCK = 8'h18;
   localparam logic [7:0] KEY_FIRST  = 8'h80;
   localparam logic [7:0] KEY_SECOND = 8'h86;

   typedef enum logic [1:0] {
      KS_IDLE  = 2'd0,
      KS_ARMED = 2'd1,
      KS_OPEN  = 2'd2
   } key_state_t;

   typedef struct packed {
      logic tmo_en;    // bit 5
      logic rst_en;    // bit 4
      logic rst_type;  // bit 3
      logic fine_pre;  // bit 2
   } wd_cfg_t;
endpackage

// File: rtl/wdog_keyseq.sv
`timescale 1ns/1ps
module wdog_keyseq
   import wdog_keyed_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic       at_key,
   input  logic       at_prot,
   input  logic [7:0] data,
   output logic       grant
);
   key_state_t st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= KS_IDLE;
      end else if (wr) begin
         if (at_key) begin
            if (data == KEY_FIRST)
               st_q <= KS_ARMED;
            else if (st_q == KS_ARMED && data == KEY_SECOND)
               st_q <= KS_OPEN;
            else
               st_q <= KS_IDLE;
         end else if (at_prot) begin
            st_q <= KS_IDLE;
         end else if (st_q == KS_ARMED) begin
            st_q <= KS_IDLE;
         end
      end
   end

   assign grant = (st_q == KS_OPEN);
endmodule

// File: rtl/wdog_prescaler.sv
`timescale 1ns/1ps
module wdog_prescaler #(
   parameter int COARSE_SH = 15,
   parameter int FINE_SH   = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   input  logic fine_sel,
   output logic tick
);
   localparam int PW = COARSE_SH;
   localparam logic [PW-1:0] LIM_C = {PW{1'b1}};
   localparam logic [PW-1:0] LIM_F = PW'((64'd1 << FINE_SH) - 64'd1);

   initial begin
      if (FINE_SH < 1 || FINE_SH > COARSE_SH || COARSE_SH > 30)
         $error("wdog_prescaler: need 1 <= FINE_SH <= COARSE_SH <= 30");
   end

   logic [PW-1:0] cnt_q;
   logic [PW-1:0] lim;

   generate
      if (FINE_SH == COARSE_SH) begin : g_single
         logic unused_sel;
         assign unused_sel = fine_sel;
         assign lim = LIM_C;
      end else begin : g_dual
         assign lim = fine_sel ? LIM_F : LIM_C;
      end
   endgenerate

   assign tick = run && !restart && (cnt_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart || !run || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter #(
   parameter int PRE_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             start,
   input  logic             tick,
   input  logic             hold_mode,
   input  logic [PRE_W-1:0] pv1,
   input  logic [PRE_W-1:0] pv2,
   output logic [PRE_W-1:0] count,
   output logic             halted,
   output logic             expire
);
   logic stage_q;

   assign expire = en && !halted && !start && tick && stage_q && (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= '0;
         stage_q <= 1'b0;
         halted  <= 1'b0;
      end else if (start) begin
         count   <= pv1;
         stage_q <= 1'b0;
         halted  <= 1'b0;
      end else if (en && !halted && tick) begin
         if (count != '0) begin
            count <= count - 1'b1;
         end else if (!stage_q) begin
            stage_q <= 1'b1;
            count   <= pv2;
         end else if (hold_mode) begin
            halted <= 1'b1;
         end else begin
            stage_q <= 1'b0;
            count   <= pv1;
         end
      end
   end
endmodule

// File: rtl/wdog_keyed.sv
`timescale 1ns/1ps
module wdog_keyed
   import wdog_keyed_pkg::*;
#(
   parameter int PRE_W     = 20,
   parameter int COARSE_SH = 15,
   parameter int FINE_SH   = 5,
   parameter int RST_CYC   = 16,
   parameter int AW        = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [31:0]   bus_wdata,
   output logic [31:0]   bus_rdata,
   output logic          rst_out,
   output logic          rst_kind,
   output logic          tmo_out
);
   localparam int RCW = $clog2(RST_CYC + 1);

   initial begin
      if (PRE_W < 1 || PRE_W > 32) $error("wdog_keyed: PRE_W out of 1..32");
      if (RST_CYC < 1)             $error("wdog_keyed: RST_CYC must be >= 1");
      if (AW < 5 || AW > 8)        $error("wdog_keyed: AW out of 5..8");
   end

   // address decode
   logic at_pv1, at_pv2, at_key, at_rl1, at_cfg, at_lck, at_prot;
   assign at_pv1  = bus_addr == AW'(OFF_PV1);
   assign at_pv2  = bus_addr == AW'(OFF_PV2);
   assign at_key  = bus_addr == AW'(OFF_KEY);
   assign at_rl1  = bus_addr == AW'(OFF_RL1);
   assign at_cfg  = bus_addr == AW'(OFF_CFG);
   assign at_lck  = bus_addr == AW'(OFF_LCK);
   assign at_prot = at_pv1 || at_pv2 || at_rl1;

   logic grant;
   wdog_keyseq u_key (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (bus_wr),
      .at_key (at_key),
      .at_prot(at_prot),
      .data   (bus_wdata[7:0]),
      .grant  (grant)
   );

   // register file
   logic [PRE_W-1:0] pv1_q, pv2_q;
   wd_cfg_t          cfg_q;
   logic             lock_q, en_q, hold_q;
   logic             tmo_flag;
   logic             acc, reload_go, clr_go, lck_wr, en_rise, start;

   assign acc       = bus_wr && at_prot && grant;
   assign reload_go = acc && at_rl1 && bus_wdata[0];
   assign clr_go    = acc && at_rl1 && bus_wdata[1];
   assign lck_wr    = bus_wr && at_lck && !lock_q;
   assign en_rise   = lck_wr && bus_wdata[1] && !en_q;
   assign start     = en_rise || reload_go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pv1_q  <= '0;
         pv2_q  <= '0;
         cfg_q  <= '0;
         lock_q <= 1'b0;
         en_q   <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         if (acc && at_pv1 && !lock_q) pv1_q <= bus_wdata[PRE_W-1:0];
         if (acc && at_pv2 && !lock_q) pv2_q <= bus_wdata[PRE_W-1:0];
         if (bus_wr && at_cfg && !lock_q) cfg_q <= wd_cfg_t'(bus_wdata[5:2]);
         if (lck_wr) begin
            lock_q <= bus_wdata[0];
            en_q   <= bus_wdata[1];
            hold_q <= bus_wdata[2];
         end
      end
   end

   // timing chain
   logic             tick, halted, expire;
   logic [PRE_W-1:0] count;

   wdog_prescaler #(.COARSE_SH(COARSE_SH), .FINE_SH(FINE_SH)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en_q && !halted),
      .restart (start),
      .fine_sel(cfg_q.fine_pre),
      .tick    (tick)
   );

   wdog_counter #(.PRE_W(PRE_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_q),
      .start    (start),
      .tick     (tick),
      .hold_mode(hold_q),
      .pv1      (pv1_q),
      .pv2      (pv2_q),
      .count    (count),
      .halted   (halted),
      .expire   (expire)
   );

   // sticky flag and reset pulse
   logic [RCW-1:0] rcnt_q;
   logic           kind_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo_flag <= 1'b0;
         rcnt_q   <= '0;
         kind_q   <= 1'b0;
      end else begin
         if (expire)      tmo_flag <= 1'b1;
         else if (clr_go) tmo_flag <= 1'b0;
         if (expire && cfg_q.rst_en) begin
            rcnt_q <= RCW'(RST_CYC);
            kind_q <= cfg_q.rst_type;
         end else if (rcnt_q != '0) begin
            rcnt_q <= rcnt_q - 1'b1;
         end
      end
   end

   assign rst_out  = (rcnt_q != '0);
   assign rst_kind = rst_out && kind_q;
   assign tmo_out  = tmo_flag && cfg_q.tmo_en;

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (at_pv1)      bus_rdata = 32'(pv1_q);
      else if (at_pv2) bus_rdata = 32'(pv2_q);
      else if (at_rl1) bus_rdata = {30'd0, tmo_flag, 1'b0};
      else if (at_cfg) bus_rdata = {26'd0, cfg_q, 2'b00};
      else if (at_cnt_sel()) bus_rdata = 32'(count);
      else if (at_lck) bus_rdata = {29'd0, hold_q, en_q, lock_q};
   end

   function automatic logic at_cnt_sel();
      return bus_addr == AW'(OFF_CNT);
   endfunction

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;
endmodule

// File: rtl/wdog_keyed_chk.sv
`timescale 1ns/1ps
module wdog_keyed_chk
   import wdog_keyed_pkg::*;
#(
   parameter int PRE_W   = 20,
   parameter int RST_CYC = 16,
   parameter int AW      = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [AW-1:0]    bus_addr,
   input logic [31:0]      bus_wdata,
   input logic             grant,
   input logic             tmo_flag,
   input logic             lock_q,
   input logic [3:0]       cfg_bits,
   input logic [PRE_W-1:0] pv1_q,
   input logic [PRE_W-1:0] pv2_q,
   input logic             rst_out
);
   int hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hi_cnt <= 0;
      else if (rst_out) hi_cnt <= hi_cnt + 1;
      else              hi_cnt <= 0;
   end

   assert_pv1_keyed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pv1_q) |-> $past(grant));
   assert_pv2_keyed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pv2_q) |-> $past(grant));
   assert_flag_clear_keyed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tmo_flag) |-> $past(bus_wr && bus_addr == AW'(OFF_RL1) && bus_wdata[1] && grant));
   assert_rst_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_out |-> tmo_flag);
   assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hi_cnt <= RST_CYC);
   assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);
   assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable(cfg_bits));
endmodule

bind wdog_keyed wdog_keyed_chk #(.PRE_W(PRE_W), .RST_CYC(RST_CYC), .AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .grant    (grant),
   .tmo_flag (tmo_flag),
   .lock_q   (lock_q),
   .cfg_bits (cfg_q),
   .pv1_q    (pv1_q),
   .pv2_q    (pv2_q),
   .rst_out  (rst_out)
);

// File: tb/wdog_keyed_test.sv
`timescale 1ns/1ps
module wdog_keyed_test;
   localparam int PW = 8, CS = 4, FS = 2, RC = 3;
   localparam logic [5:0] A_PV1 = 6'h00, A_PV2 = 6'h04, A_KEY = 6'h0C,
                          A_RL1 = 6'h0D, A_CFG = 6'h10, A_CNT = 6'h14, A_LCK = 6'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rst_out, rst_kind, tmo_out;

   int vectors = 0, miscompares = 0, rises = 0;
   logic prev_rst = 1'b0;

   always #10 clk = ~clk;

   wdog_keyed #(.PRE_W(PW), .COARSE_SH(CS), .FINE_SH(FS), .RST_CYC(RC), .AW(6)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rst_out(rst_out), .rst_kind(rst_kind), .tmo_out(tmo_out));

   always @(negedge clk) begin
      if (rst_out && !prev_rst) rises++;
      prev_rst <= rst_out;
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s actual %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic kwr(input logic [5:0] a, input logic [31:0] d);
      wr(A_KEY, 32'h80);
      wr(A_KEY, 32'h86);
      wr(a, d);
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] v);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic wait_flag(input int lim, output int n);
      n = 0;
      bus_addr = A_RL1;
      #1;
      while (!bus_rdata[1] && n < lim) begin
         @(negedge clk);
         #1;
         n++;
      end
   endtask

   task automatic stop_clear();
      wr(A_LCK, 32'h0);
      kwr(A_RL1, 32'h2);
   endtask

   initial begin
      logic [31:0] v, c1;
      int n, h;
      repeat (3) @(negedge clk);
      // R12 reset state
      foreach (A_ALL[i]) begin
         rd(A_ALL[i], v);
         chk("R12 reset read", v, 0);
      end
      chk("R12 outputs", {rst_out, tmo_out}, 0);
      rst_n = 1'b1;

      // R1 key guard
      wr(A_PV1, 32'h3);       rd(A_PV1, v); chk("R1 unkeyed write", v, 0);
      kwr(A_PV1, 32'h3);      rd(A_PV1, v); chk("R1 keyed write", v, 3);
      wr(A_KEY, 32'h80); wr(A_CFG, 32'h0); wr(A_KEY, 32'h86); wr(A_PV2, 32'h9);
      rd(A_PV2, v); chk("R1 interrupted key", v, 0);
      wr(A_KEY, 32'h80); wr(A_KEY, 32'h11); wr(A_KEY, 32'h86); wr(A_PV2, 32'h9);
      rd(A_PV2, v); chk("R1 wrong key byte", v, 0);
      // R2 single use
      kwr(A_PV2, 32'h2); wr(A_PV2, 32'h5);
      rd(A_PV2, v); chk("R2 second write ignored", v, 2);

      // R3 sweep over preloads and prescaler select, R7 no pulse
      rises = 0;
      for (int sel = 0; sel < 2; sel++)
         for (int p1 = 0; p1 < 4; p1++)
            for (int p2 = 0; p2 < 3; p2++) begin
               kwr(A_PV1, 32'(p1)); kwr(A_PV2, 32'(p2));
               wr(A_CFG, 32'(sel << 2));
               wr(A_LCK, 32'h6);
               wait_flag(1000, n);
               chk("R3 timeout delay", 32'(n), 32'((p1 + p2 + 2) * (sel ? (1 << FS) : (1 << CS))));
               stop_clear();
               rd(A_RL1, v); chk("R6 flag cleared", v, 0);
            end
      chk("R7 no pulse when disabled", 32'(rises), 0);

      // R4 counter readback
      kwr(A_PV1, 32'h5); kwr(A_PV2, 32'h7); wr(A_CFG, 32'h0);
      wr(A_LCK, 32'h6);
      rd(A_CNT, v); chk("R4 count at start", v, 5);
      repeat (95) @(negedge clk);
      rd(A_CNT, v); chk("R4 end of stage one", v, 0);
      @(negedge clk);
      rd(A_CNT, v); chk("R4 stage two load", v, 7);
      wait_flag(1000, n);
      repeat (50) @(negedge clk);
      rd(A_RL1, v); chk("R6 flag sticky", v, 2);
      rd(A_CNT, v); chk("R11 hold at zero", v, 0);
      // R5 reload
      kwr(A_RL1, 32'h1);
      rd(A_CNT, v); chk("R5 reload count", v, 5);
      rd(A_RL1, v); chk("R5 flag unchanged", v, 2);
      kwr(A_RL1, 32'h3);
      wait_flag(1000, n);
      chk("R5 timing after reload", 32'(n), 224);

      // R7 reset pulse, R8 timeout output
      stop_clear();
      kwr(A_PV1, 32'h1); kwr(A_PV2, 32'h0); wr(A_CFG, 32'h38);
      wr(A_LCK, 32'h6);
      wait_flag(1000, n);
      chk("R3 short delay", 32'(n), 48);
      chk("R7 pulse with flag", {rst_out, rst_kind}, 2'b11);
      h = 0;
      while (rst_out && h < 50) begin h++; @(negedge clk); end
      chk("R7 pulse length", 32'(h), RC);
      rd(A_RL1, v); chk("R6 flag survives pulse", v, 2);
      chk("R8 tmo_out on", 32'(tmo_out), 1);
      wr(A_CFG, 32'h10);
      chk("R8 tmo_out off", 32'(tmo_out), 0);

      // R11 expiry modes
      stop_clear();
      kwr(A_PV1, 32'h0); kwr(A_PV2, 32'h0);
      rises = 0;
      wr(A_LCK, 32'h2);
      repeat (100) @(negedge clk);
      chk("R11 restart mode pulses", 32'(rises), 3);
      stop_clear();
      repeat (5) @(negedge clk);
      rises = 0;
      wr(A_LCK, 32'h6);
      repeat (100) @(negedge clk);
      chk("R11 hold mode pulses", 32'(rises), 1);

      // R9 stop
      stop_clear();
      kwr(A_PV1, 32'h9);
      wr(A_LCK, 32'h2);
      repeat (40) @(negedge clk);
      wr(A_LCK, 32'h0);
      rd(A_CNT, c1); chk("R9 count at stop", c1, 7);
      repeat (300) @(negedge clk);
      rd(A_CNT, v); chk("R9 count holds", v, c1);
      rd(A_RL1, v); chk("R9 no timeout", v, 0);

      // R10 lock
      wr(A_CFG, 32'h04); kwr(A_PV1, 32'h3);
      wr(A_LCK, 32'h3);
      rd(A_LCK, v); chk("R10 lock set", v, 3);
      wr(A_CFG, 32'h0);   rd(A_CFG, v); chk("R10 cfg frozen", v, 32'h04);
      kwr(A_PV1, 32'h8);  rd(A_PV1, v); chk("R10 preload frozen", v, 3);
      wr(A_LCK, 32'h0);   rd(A_LCK, v); chk("R10 lock sticky", v, 3);
      kwr(A_RL1, 32'h1);  rd(A_CNT, v); chk("R10 reload while locked", v, 3);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd(A_LCK, v); chk("R10 lock cleared by rst_n", v, 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   localparam logic [5:0] A_ALL [6] = '{6'h00, 6'h04, 6'h0D, 6'h10, 6'h14, 6'h18};

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired, run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule